// File: doc/BRIEF.md
# Virtual Circuit Label-Swapping Forwarder

This block sits on one input port of a connection-oriented packet switch. It holds a private forwarding table indexed by the incoming virtual circuit label. Each installed entry names an egress port, the label to use on the next link and a two-bit handling priority. A packet header offered on the input handshake is looked up by its label. On a hit, the label field is overwritten with the outgoing label, and the header leaves with the chosen port and priority beside it. On a miss, the header is discarded and a one-cycle drop pulse is raised.

Connection setup writes an entry through the configuration inputs, and connection release clears it. Labels only have meaning on the link they arrived on, so every port instance keeps its own table. The lookup has a fixed two-cycle latency and can take one header per cycle while the downstream side keeps up.

Top module: `vc_fwd`

## Requirements
- R1: After reset every table entry is invalid, out_valid_o and drop_o are low, and in_ready_o is high.
- R2: A cycle with cfg_set_i high installs the entry at index cfg_vci_i, holding port cfg_port_i, outgoing label cfg_out_vci_i and priority cfg_prio_i.
- R3: A cycle with cfg_clr_i high invalidates the entry at cfg_vci_i. When cfg_set_i and cfg_clr_i are both high in the same cycle, the clear wins.
- R4: The incoming label is header bits [7:0]. On a hit, out_hdr_o equals the input header with bits [7:0] replaced by the entry's outgoing label, and out_port_o and out_prio_o carry the entry's port and priority.
- R5: A header whose entry is invalid is never presented on the output. drop_o is high for exactly one cycle, two clock edges after the header is accepted, and this holds even while the output is stalled.
- R6: A header accepted on a clock edge appears on the output after the second following edge when out_ready_i is high.
- R7: Whenever out_ready_i is high, in_ready_o is high, so back-to-back headers stream at one per cycle.
- R8: While out_valid_o is high and out_ready_i is low, the output header, port and priority stay unchanged. Headers are neither lost nor reordered.
- R9: A header accepted on the same edge as a configuration write or clear of its entry uses the entry as it was before that write. Headers accepted later use the new entry.
- R10: Writing or clearing one label leaves all other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_set_i | input | 1 | Install entry at cfg_vci_i |
| cfg_clr_i | input | 1 | Invalidate entry at cfg_vci_i (wins over set) |
| cfg_vci_i | input | 8 | Table index (incoming label) |
| cfg_port_i | input | 4 | Egress port to store |
| cfg_out_vci_i | input | 8 | Outgoing label to store |
| cfg_prio_i | input | 2 | Priority to store |
| in_valid_i | input | 1 | Header offered |
| in_ready_o | output | 1 | Header can be taken |
| in_hdr_i | input | HDR_W (32) | Incoming header, label in bits [7:0] |
| out_valid_o | output | 1 | Rewritten header present |
| out_ready_i | input | 1 | Downstream takes header |
| out_hdr_o | output | HDR_W (32) | Header with outgoing label |
| out_port_o | output | 4 | Chosen egress port |
| out_prio_o | output | 2 | Connection priority |
| drop_o | output | 1 | One-cycle pulse for a header with no entry |

## Verification
The bench offers a header on the same edge that installs or clears its entry. A design that reads the table one cycle late would forward a packet before setup, or drop one on a live connection. It then stalls the output with a header parked in the last stage while a miss flows behind it. A design that ties drops to downstream readiness would then delay or lose the drop pulse, and one with a weak hold would corrupt the parked header. Back-to-back streaming checks every header at exactly two cycles of latency, which exposes any added bubble or misordering. Setting and clearing together, plus neighbour labels, catch a wrong clear priority and writes that leak into other entries.

// File: rtl/vc_fwd_pkg.sv
package vc_fwd_pkg;
  localparam int unsigned VCI_W  = 8;
  localparam int unsigned PORT_W = 4;
  localparam int unsigned PRIO_W = 2;
  localparam int unsigned DEPTH  = 1 << VCI_W;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic [VCI_W-1:0]  vci;
    logic [PRIO_W-1:0] prio;
  } vc_route_t;
endpackage

// File: rtl/vc_fwd_table.sv
module vc_fwd_table
  import vc_fwd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [VCI_W-1:0] wr_idx_i,
  input  vc_route_t        wr_route_i,
  input  logic [VCI_W-1:0] rd_idx_i,
  output logic             rd_hit_o,
  output vc_route_t        rd_route_o
);
  logic [DEPTH-1:0] vld_vec;
  vc_route_t        route_arr [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gen_ent
    logic      vld_q;
    vc_route_t route_q;
    logic      sel;

    assign sel = wr_idx_i == VCI_W'(g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 vld_q <= 1'b0;
      else if (sel && clr_i)       vld_q <= 1'b0;
      else if (sel && set_i)       vld_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel && set_i && !clr_i) route_q <= wr_route_i;
    end

    assign vld_vec[g]   = vld_q;
    assign route_arr[g] = route_q;
  end

  // read before write: same-edge updates are invisible to this read
  assign rd_hit_o   = vld_vec[rd_idx_i];
  assign rd_route_o = route_arr[rd_idx_i];
endmodule

// File: rtl/vc_fwd_lookup.sv
module vc_fwd_lookup
  import vc_fwd_pkg::*;
#(
  parameter int unsigned HDR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             adv_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             hit_i,
  input  vc_route_t        route_i,
  output logic             vld_o,
  output logic [HDR_W-1:0] hdr_o,
  output logic             hit_o,
  output vc_route_t        route_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_o <= 1'b0;
    else if (acc_i) vld_o <= 1'b1;
    else if (adv_i) vld_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o   <= '0;
      hit_o   <= 1'b0;
      route_o <= '0;
    end else if (acc_i) begin
      hdr_o   <= hdr_i;
      hit_o   <= hit_i;
      route_o <= route_i;
    end
  end
endmodule

// File: rtl/vc_fwd_rewrite.sv
module vc_fwd_rewrite
  import vc_fwd_pkg::*;
#(
  parameter int unsigned HDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              miss_i,
  input  logic              pop_i,
  input  logic [HDR_W-1:0]  hdr_i,
  input  vc_route_t         route_i,
  output logic              vld_o,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [PORT_W-1:0] port_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              drop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      drop_o <= 1'b0;
    end else begin
      drop_o <= miss_i;
      if (take_i)     vld_o <= 1'b1;
      else if (pop_i) vld_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_o  <= '0;
      port_o <= '0;
      prio_o <= '0;
    end else if (take_i) begin
      hdr_o  <= {hdr_i[HDR_W-1:VCI_W], route_i.vci};
      port_o <= route_i.port;
      prio_o <= route_i.prio;
    end
  end
endmodule

// File: rtl/vc_fwd.sv
module vc_fwd
  import vc_fwd_pkg::*;
#(
  parameter int unsigned HDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_set_i,
  input  logic              cfg_clr_i,
  input  logic [VCI_W-1:0]  cfg_vci_i,
  input  logic [PORT_W-1:0] cfg_port_i,
  input  logic [VCI_W-1:0]  cfg_out_vci_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [HDR_W-1:0]  in_hdr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [HDR_W-1:0]  out_hdr_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic [PRIO_W-1:0] out_prio_o,
  output logic              drop_o
);
  vc_route_t        wr_route, rd_route, s1_route;
  logic             rd_hit, s1_vld, s1_hit, s1_adv, s2_free, acc;
  logic [HDR_W-1:0] s1_hdr;

  assign wr_route = '{port: cfg_port_i, vci: cfg_out_vci_i, prio: cfg_prio_i};

  // misses retire without waiting for the output stage
  assign s2_free    = !out_valid_o || out_ready_i;
  assign s1_adv     = s1_vld && (!s1_hit || s2_free);
  assign in_ready_o = !s1_vld || s1_adv;
  assign acc        = in_valid_i && in_ready_o;

  vc_fwd_table u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (cfg_set_i),
    .clr_i      (cfg_clr_i),
    .wr_idx_i   (cfg_vci_i),
    .wr_route_i (wr_route),
    .rd_idx_i   (in_hdr_i[VCI_W-1:0]),
    .rd_hit_o   (rd_hit),
    .rd_route_o (rd_route)
  );

  vc_fwd_lookup #(.HDR_W(HDR_W)) u_lookup (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc),
    .adv_i   (s1_adv),
    .hdr_i   (in_hdr_i),
    .hit_i   (rd_hit),
    .route_i (rd_route),
    .vld_o   (s1_vld),
    .hdr_o   (s1_hdr),
    .hit_o   (s1_hit),
    .route_o (s1_route)
  );

  vc_fwd_rewrite #(.HDR_W(HDR_W)) u_rewrite (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (s1_adv && s1_hit),
    .miss_i  (s1_adv && !s1_hit),
    .pop_i   (out_ready_i),
    .hdr_i   (s1_hdr),
    .route_i (s1_route),
    .vld_o   (out_valid_o),
    .hdr_o   (out_hdr_o),
    .port_o  (out_port_o),
    .prio_o  (out_prio_o),
    .drop_o  (drop_o)
  );
endmodule

// File: rtl/vc_fwd_chk.sv
module vc_fwd_chk
  import vc_fwd_pkg::*;
#(
  parameter int unsigned HDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_set_i,
  input logic              cfg_clr_i,
  input logic [VCI_W-1:0]  cfg_vci_i,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic [VCI_W-1:0]  in_vci,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [HDR_W-1:0]  out_hdr_o,
  input logic [PORT_W-1:0] out_port_o,
  input logic [PRIO_W-1:0] out_prio_o,
  input logic              drop_o
);
  logic [DEPTH-1:0] shadow_q;
  logic             acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        shadow_q <= '0;
    else if (cfg_clr_i) shadow_q[cfg_vci_i] <= 1'b0;
    else if (cfg_set_i) shadow_q[cfg_vci_i] <= 1'b1;
  end

  assign acc = in_valid_i && in_ready_o;

  AST_MISS_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !shadow_q[in_vci] |=> ##1 drop_o);                           // R5

  AST_HIT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && shadow_q[in_vci] |=> ##1 !drop_o);                           // R9

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_hdr_o)
      && $stable(out_port_o) && $stable(out_prio_o));                   // R8

  AST_READY_FLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |-> in_ready_o);                                        // R7
endmodule

bind vc_fwd vc_fwd_chk #(.HDR_W(HDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_set_i   (cfg_set_i),
  .cfg_clr_i   (cfg_clr_i),
  .cfg_vci_i   (cfg_vci_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_vci      (in_hdr_i[vc_fwd_pkg::VCI_W-1:0]),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_hdr_o   (out_hdr_o),
  .out_port_o  (out_port_o),
  .out_prio_o  (out_prio_o),
  .drop_o      (drop_o)
);

// File: tb/vc_fwd_test.sv
module vc_fwd_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_set_i = 1'b0, cfg_clr_i = 1'b0;
  logic [7:0]  cfg_vci_i = '0, cfg_out_vci_i = '0;
  logic [3:0]  cfg_port_i = '0;
  logic [1:0]  cfg_prio_i = '0;
  logic        in_valid_i = 1'b0, out_ready_i = 1'b1;
  logic [31:0] in_hdr_i = '0;
  logic        in_ready_o, out_valid_o, drop_o;
  logic [31:0] out_hdr_o;
  logic [3:0]  out_port_o;
  logic [1:0]  out_prio_o;

  int n_run = 0, n_fail = 0;

  always #10 clk_i = !clk_i;

  vc_fwd uut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg(logic set, logic clr, logic [7:0] vci, logic [3:0] port,
                     logic [7:0] ovci, logic [1:0] prio);
    @(negedge clk_i);
    cfg_set_i = set; cfg_clr_i = clr; cfg_vci_i = vci;
    cfg_port_i = port; cfg_out_vci_i = ovci; cfg_prio_i = prio;
    @(negedge clk_i);
    cfg_set_i = 1'b0; cfg_clr_i = 1'b0;
  endtask

  // drives at the next negedge; result sampled two negedges later
  task automatic send(string req, logic [31:0] hdr, logic hit, logic [3:0] port,
                      logic [7:0] ovci, logic [1:0] prio);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_hdr_i = hdr;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    chk("R6", "valid early", {31'b0, out_valid_o}, 32'd0);
    @(negedge clk_i);
    chk(req, "out_valid", {31'b0, out_valid_o}, {31'b0, hit});
    chk(req, "drop", {31'b0, drop_o}, {31'b0, !hit});
    if (hit) begin
      chk(req, "hdr", out_hdr_o, {hdr[31:8], ovci});
      chk(req, "port", {28'b0, out_port_o}, {28'b0, port});
      chk(req, "prio", {30'b0, out_prio_o}, {30'b0, prio});
    end
    @(negedge clk_i);
    chk("R5", "drop one cycle", {31'b0, drop_o}, 32'd0);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1", "out_valid", {31'b0, out_valid_o}, 32'd0);
    chk("R1", "drop", {31'b0, drop_o}, 32'd0);
    chk("R1", "in_ready", {31'b0, in_ready_o}, 32'd1);
    send("R1", 32'h0000_0005, 1'b0, 0, 0, 0);
    send("R1", 32'h1234_56FF, 1'b0, 0, 0, 0);
  endtask

  task automatic t_basic;
    cfg(1, 0, 8'h12, 4'h9, 8'hA7, 2'd2);
    send("R2", 32'hDEAD_BE12, 1'b1, 4'h9, 8'hA7, 2'd2);
    send("R4", 32'h0F0F_0F12, 1'b1, 4'h9, 8'hA7, 2'd2);
  endtask

  task automatic t_neighbour;
    cfg(1, 0, 8'h13, 4'h3, 8'h01, 2'd1);
    send("R10", 32'hAAAA_AA12, 1'b1, 4'h9, 8'hA7, 2'd2);
    send("R10", 32'h5555_5513, 1'b1, 4'h3, 8'h01, 2'd1);
    send("R10", 32'h5555_5514, 1'b0, 0, 0, 0);
  endtask

  task automatic t_clear;
    cfg(0, 1, 8'h12, 0, 0, 0);
    send("R3", 32'hDEAD_BE12, 1'b0, 0, 0, 0);
    send("R3", 32'h0000_0013, 1'b1, 4'h3, 8'h01, 2'd1);
    cfg(1, 1, 8'h13, 4'hF, 8'hFF, 2'd3);
    send("R3", 32'h0000_0013, 1'b0, 0, 0, 0);
  endtask

  task automatic t_order;
    // install on the same edge as acceptance: old (invalid) entry applies
    @(negedge clk_i);
    cfg_set_i = 1; cfg_vci_i = 8'h33; cfg_port_i = 4'h6; cfg_out_vci_i = 8'h44; cfg_prio_i = 2'd3;
    in_valid_i = 1; in_hdr_i = 32'hCAFE_0033;
    @(negedge clk_i);
    cfg_set_i = 0; in_valid_i = 0;
    @(negedge clk_i);
    chk("R9", "set same edge drops", {31'b0, drop_o}, 32'd1);
    chk("R9", "set same edge no out", {31'b0, out_valid_o}, 32'd0);
    send("R9", 32'hCAFE_0033, 1'b1, 4'h6, 8'h44, 2'd3);
    // clear on the same edge: old (valid) entry still applies
    @(negedge clk_i);
    cfg_clr_i = 1; cfg_vci_i = 8'h33;
    in_valid_i = 1; in_hdr_i = 32'hBEEF_0033;
    @(negedge clk_i);
    cfg_clr_i = 0; in_valid_i = 0;
    @(negedge clk_i);
    chk("R9", "clear same edge fwd", {31'b0, out_valid_o}, 32'd1);
    chk("R9", "clear same edge hdr", out_hdr_o, 32'hBEEF_0044);
    send("R9", 32'hBEEF_0033, 1'b0, 0, 0, 0);
  endtask

  task automatic t_stream;
    cfg(1, 0, 8'h20, 4'h1, 8'h80, 2'd0);
    cfg(1, 0, 8'h21, 4'h2, 8'h81, 2'd1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      chk("R7", "ready", {31'b0, in_ready_o}, 32'd1);
      if (k >= 2) begin
        chk("R7", "stream valid", {31'b0, out_valid_o}, 32'd1);
        chk("R6", "stream hdr", out_hdr_o, {24'h00_0100 + 24'(k - 2), ((k % 2) == 0) ? 8'h80 : 8'h81});
        chk("R7", "stream port", {28'b0, out_port_o}, ((k % 2) == 0) ? 32'd1 : 32'd2);
      end
      if (k < 6) begin
        in_valid_i = 1; in_hdr_i = {24'h00_0100 + 24'(k), ((k % 2) == 0) ? 8'h20 : 8'h21};
      end else in_valid_i = 0;
    end
    @(negedge clk_i);
    chk("R7", "stream drained", {31'b0, out_valid_o}, 32'd0);
  endtask

  task automatic t_stall;
    @(negedge clk_i);
    out_ready_i = 0;
    in_valid_i = 1; in_hdr_i = 32'h0000_0A20;            // A
    @(negedge clk_i);
    in_hdr_i = 32'h0000_0B21;                             // B
    @(negedge clk_i);
    in_valid_i = 0;
    chk("R8", "ready low when full", {31'b0, in_ready_o}, 32'd0);
    chk("R8", "A parked", out_hdr_o, 32'h0000_0A80);
    repeat (3) @(negedge clk_i);
    chk("R8", "A held", out_hdr_o, 32'h0000_0A80);
    chk("R8", "A port held", {28'b0, out_port_o}, 32'd1);
    out_ready_i = 1;
    @(negedge clk_i);
    chk("R8", "B next", out_hdr_o, 32'h0000_0B81);
    chk("R8", "B valid", {31'b0, out_valid_o}, 32'd1);
    out_ready_i = 0;
    // miss behind a parked header still drops on time
    in_valid_i = 1; in_hdr_i = 32'h0000_0C77;
    @(negedge clk_i);
    in_valid_i = 0;
    @(negedge clk_i);
    chk("R5", "drop under stall", {31'b0, drop_o}, 32'd1);
    chk("R8", "B still held", out_hdr_o, 32'h0000_0B81);
    out_ready_i = 1;
    @(negedge clk_i);
    chk("R5", "drop pulse ends", {31'b0, drop_o}, 32'd0);
    chk("R8", "empty after B", {31'b0, out_valid_o}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_basic();
        t_neighbour();
        t_clear();
        t_order();
        t_stream();
        t_stall();
      end
      begin
        repeat (200000) @(posedge clk_i);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule